// File: doc/BRIEF.md
# Phase Lock Detector with Consecutive-Comparison Qualification

This block watches the two pulse outputs of a tristate phase-frequency detector and decides whether the loop around it has settled. A fast sampling clock measures every phase comparison. A comparison window opens when either the up or the down pulse goes high. It closes when both are low again, so the measured width is the length of the wider pulse. A comparison counts as tight when that width, in sampling-clock cycles, is below a phase-error limit. The default limit of 62 cycles at 250 MHz is just under 250 ns.

The lock flag goes high only after seven tight comparisons in a row. One loose comparison throws away the whole run. A two-bit control code can switch the detector off. While it is off, the run count is held at zero and the flag is driven low. The up and down inputs are assumed to be synchronous to the sampling clock.

Top module: `pll_lock_monitor`

## Requirements
- R1: While reset is asserted, and right after it is released, lockOut is 0.
- R2: A comparison lasts while upIn or dnIn (or both) is high. Its width is the number of sampling edges at which that OR is high. The comparison is judged at the first edge that samples both inputs low.
- R3: lockOut goes to 1 one edge after the seventh consecutive tight comparison is judged. lockOut changes only when a comparison is judged or when the control code changes.
- R4: After only six consecutive tight comparisons, lockOut remains 0.
- R5: A loose comparison clears the run count and drops lockOut at the edge that judges it. Seven fresh tight comparisons are then needed for lock.
- R6: The run count stops at seven. Further tight comparisons keep lockOut at 1 and do not wrap the count.
- R7: ctrlCode = 2'b10 (bit 1 high, bit 0 low) deactivates the detector. From the next edge on, lockOut is 0 and the run count is zero, and pulses seen while it is off are not counted.
- R8: The codes 2'b00, 2'b01 and 2'b11 all leave the detector running normally.
- R9: If deactivation and the judging of a comparison fall on the same edge, deactivation wins: lockOut stays 0 and the run count restarts from zero.
- R10: A comparison is tight when its width is PHASE_LIMIT-1 or less. A width of exactly PHASE_LIMIT, or any longer width, is loose. The width counter saturates at PHASE_LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| upIn | input | 1 | Up pulse from the phase detector |
| dnIn | input | 1 | Down pulse from the phase detector |
| ctrlCode | input | 2 | Control code; 2'b10 deactivates the detector |
| lockOut | output | 1 | Lock flag, 1 when locked |

## Verification
The seventh tight comparison can be judged on the same edge at which the control code switches the detector off. The bench sets this up by dropping the closing pulse and writing the off code in the same half-cycle. It then expects lockOut to stay low. After the detector is switched back on, it expects lock to need a full seven fresh comparisons. A loose comparison arriving on top of an established lock is judged in the same way: lockOut must drop at that edge, and the recount must start from zero.

// File: rtl/pll_lock_pkg.sv
`timescale 1ns/1ps
package pll_lock_pkg;
  localparam logic [1:0] DET_OFF_CODE = 2'b10;

  typedef struct packed {
    logic pulseOn;  // a comparison window is open and counted
    logic evalNow;  // the window closed this cycle: judge it
    logic clrAll;   // detector deactivated: zero everything
  } ctlStrobes_t;
endpackage

// File: rtl/pll_lock_ctrl.sv
`timescale 1ns/1ps
module pll_lock_ctrl
  import pll_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        upIn,
  input  logic        dnIn,
  input  logic [1:0]  ctrlCode,
  output ctlStrobes_t strobes
);
  logic anyPulse;
  logic actPrev;
  logic detOff;

  assign anyPulse = upIn | dnIn;
  assign detOff   = (ctrlCode == DET_OFF_CODE);

  always_ff @(posedge clk) begin
    if (!rstN) actPrev <= 1'b0;
    else       actPrev <= anyPulse;
  end

  always_comb begin
    strobes.clrAll  = detOff;
    strobes.pulseOn = anyPulse & ~detOff;
    strobes.evalNow = actPrev & ~anyPulse & ~detOff;
  end
endmodule

// File: rtl/pll_lock_dpath.sv
`timescale 1ns/1ps
module pll_lock_dpath
  import pll_lock_pkg::*;
#(
  parameter int PHASE_LIMIT = 62,
  parameter int LOCK_COUNT  = 7,
  localparam int WIDTH_W = $clog2(PHASE_LIMIT + 1),
  localparam int CNT_W   = $clog2(LOCK_COUNT + 1)
)(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  output logic [WIDTH_W-1:0] widthCnt,
  output logic [CNT_W-1:0]   goodCnt,
  output logic               lockReg
);
  localparam logic [WIDTH_W-1:0] LIMIT_V = WIDTH_W'(PHASE_LIMIT);
  localparam logic [CNT_W-1:0]   FULL_V  = CNT_W'(LOCK_COUNT);

  logic isTight;
  logic [CNT_W-1:0] goodNext;

  assign isTight = (widthCnt < LIMIT_V);

  always_comb begin
    if (!isTight)              goodNext = '0;
    else if (goodCnt == FULL_V) goodNext = goodCnt;
    else                        goodNext = goodCnt + 1'b1;
  end

  // pulse width measurement, saturating at the limit
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clrAll || strobes.evalNow)
      widthCnt <= '0;
    else if (strobes.pulseOn && widthCnt != LIMIT_V)
      widthCnt <= widthCnt + 1'b1;
  end

  // consecutive tight comparisons and the flag
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clrAll) begin
      goodCnt <= '0;
      lockReg <= 1'b0;
    end else if (strobes.evalNow) begin
      goodCnt <= goodNext;
      lockReg <= (goodNext == FULL_V);
    end
  end
endmodule

// File: rtl/pll_lock_monitor.sv
`timescale 1ns/1ps
module pll_lock_monitor
  import pll_lock_pkg::*;
#(
  parameter int PHASE_LIMIT = 62,
  parameter int LOCK_COUNT  = 7
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       upIn,
  input  logic       dnIn,
  input  logic [1:0] ctrlCode,
  output logic       lockOut
);
  localparam int WIDTH_W = $clog2(PHASE_LIMIT + 1);
  localparam int CNT_W   = $clog2(LOCK_COUNT + 1);

  ctlStrobes_t        strobes;
  logic [WIDTH_W-1:0] widthCnt;
  logic [CNT_W-1:0]   goodCnt;
  logic               lockReg;

  pll_lock_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .upIn(upIn), .dnIn(dnIn),
    .ctrlCode(ctrlCode), .strobes(strobes)
  );

  pll_lock_dpath #(.PHASE_LIMIT(PHASE_LIMIT), .LOCK_COUNT(LOCK_COUNT)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .widthCnt(widthCnt), .goodCnt(goodCnt), .lockReg(lockReg)
  );

  assign lockOut = lockReg;
endmodule

// File: rtl/pll_lock_monitor_chk.sv
`timescale 1ns/1ps
module pll_lock_monitor_chk
  import pll_lock_pkg::*;
#(
  parameter int PHASE_LIMIT = 62,
  parameter int LOCK_COUNT  = 7,
  localparam int WIDTH_W = $clog2(PHASE_LIMIT + 1),
  localparam int CNT_W   = $clog2(LOCK_COUNT + 1)
)(
  input logic               clk,
  input logic               rstN,
  input logic               upIn,
  input logic               dnIn,
  input logic [1:0]         ctrlCode,
  input logic               lockOut,
  input logic [WIDTH_W-1:0] widthCnt,
  input logic [CNT_W-1:0]   goodCnt
);
  logic act;
  assign act = upIn | dnIn;

  // R7
  off_forces_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlCode == DET_OFF_CODE) |-> (!lockOut && goodCnt == '0));

  // R3
  rise_after_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockOut) |-> (!$past(act) && $past(act, 2)));

  // R3
  lock_means_full_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockOut |-> (goodCnt == CNT_W'(LOCK_COUNT)));

  // R5
  fall_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockOut) |-> ($past(ctrlCode == DET_OFF_CODE) ||
                        (!$past(act) && $past(act, 2))));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    widthCnt <= WIDTH_W'(PHASE_LIMIT));

  // R6
  run_saturates_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(goodCnt) == CNT_W'(LOCK_COUNT) && goodCnt != '0) |-> goodCnt == CNT_W'(LOCK_COUNT));
endmodule

bind pll_lock_monitor pll_lock_monitor_chk #(
  .PHASE_LIMIT(PHASE_LIMIT), .LOCK_COUNT(LOCK_COUNT)
) u_chk (
  .clk(clk), .rstN(rstN), .upIn(upIn), .dnIn(dnIn), .ctrlCode(ctrlCode),
  .lockOut(lockOut), .widthCnt(widthCnt), .goodCnt(goodCnt)
);

// File: tb/pll_lock_monitor_tb.sv
`timescale 1ns/1ps
module pll_lock_monitor_tb;
  localparam int LIMIT = 62;

  logic clk = 1'b0;
  logic rstN;
  logic upIn, dnIn;
  logic [1:0] ctrlCode;
  logic lockOut;
  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  pll_lock_monitor u_dut (
    .clk(clk), .rstN(rstN), .upIn(upIn), .dnIn(dnIn),
    .ctrlCode(ctrlCode), .lockOut(lockOut)
  );

  task automatic expect1(input string req, input logic exp);
    nChecks++;
    if (lockOut !== exp) begin
      nFail++;
      $display("FAIL %s: lockOut=%b expected %b at %0t", req, lockOut, exp, $time);
    end
  endtask

  // drive a pulse of w sampled cycles, then wait until it has been judged
  task automatic pulse(input int w, input bit useDn);
    if (useDn) dnIn = 1'b1; else upIn = 1'b1;
    repeat (w) @(negedge clk);
    upIn = 1'b0; dnIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic goodRun(input int n);
    for (int i = 0; i < n; i++) pulse(10 + i, i[0]);
  endtask

  task automatic tReset();
    expect1("R1 reset", 1'b0);
  endtask

  task automatic tRunUp();
    pulse(1, 1'b0);  pulse(LIMIT - 1, 1'b1); pulse(30, 1'b0);
    // overlapping up and down make one window of 5 cycles (R2)
    upIn = 1'b1; repeat (3) @(negedge clk);
    dnIn = 1'b1; repeat (2) @(negedge clk);
    upIn = 1'b0; dnIn = 1'b0; @(negedge clk);
    pulse(7, 1'b1); pulse(2, 1'b0);
    expect1("R4 six tight comparisons", 1'b0);
    pulse(12, 1'b1);
    expect1("R3 seventh tight comparison", 1'b1);
  endtask

  task automatic tSaturate();
    goodRun(3);
    expect1("R6 run saturates", 1'b1);
    upIn = 1'b1; repeat (5) @(negedge clk);
    expect1("R3 flag stable mid-window", 1'b1);
    upIn = 1'b0; @(negedge clk);
    expect1("R6 still locked", 1'b1);
  endtask

  task automatic tBoundary();
    pulse(LIMIT, 1'b0);
    expect1("R10 width at limit is loose", 1'b0);
    for (int i = 0; i < 6; i++) pulse(LIMIT - 1, 1'b1);
    expect1("R5 recount after loose", 1'b0);
    pulse(LIMIT - 1, 1'b0);
    expect1("R5 relock after seven", 1'b1);
    pulse(200, 1'b1);
    expect1("R10 long pulse is loose", 1'b0);
  endtask

  task automatic tDisable();
    goodRun(7);
    expect1("R3 lock before disable", 1'b1);
    ctrlCode = 2'b10; @(negedge clk);
    expect1("R7 off drives low", 1'b0);
    goodRun(7);
    expect1("R7 pulses ignored while off", 1'b0);
    ctrlCode = 2'b00; @(negedge clk);
    goodRun(6);
    expect1("R7 count zeroed by off", 1'b0);
    pulse(9, 1'b0);
    expect1("R7 relock after enable", 1'b1);
  endtask

  task automatic tOtherCodes();
    for (int c = 0; c < 4; c++) begin
      if (c == 2) continue;
      pulse(LIMIT + 3, 1'b0);
      ctrlCode = 2'(c); @(negedge clk);
      goodRun(7);
      expect1($sformatf("R8 code %0d runs", c), 1'b1);
    end
    ctrlCode = 2'b00;
  endtask

  task automatic tCollide();
    pulse(LIMIT, 1'b1);
    goodRun(6);
    upIn = 1'b1; repeat (8) @(negedge clk);
    upIn = 1'b0; ctrlCode = 2'b10;
    @(negedge clk);
    expect1("R9 off wins over judge", 1'b0);
    ctrlCode = 2'b00; @(negedge clk);
    goodRun(6);
    expect1("R9 run restarted", 1'b0);
    pulse(4, 1'b1);
    expect1("R9 lock after fresh seven", 1'b1);
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; upIn = 1'b0; dnIn = 1'b0; ctrlCode = 2'b00;
    repeat (3) @(negedge clk);
    expect1("R1 during reset", 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRunUp();
    tSaturate();
    tBoundary();
    tDisable();
    tOtherCodes();
    tCollide();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule